// File: doc/BRIEF.md
# Programmable Forwarded Clock Pattern Generator

This block builds the free-running forwarded clock of a source-synchronous, dual-data system port from a fast core clock. The waveform is not produced by a counter divider. It comes from a 16-bit bit pattern that software loads, and the pattern is walked at half-core-clock resolution. Each core cycle therefore yields two half-cycle clock levels, which a double-data-rate output cell at the pad serializes. Because of this, ratios with an odd number of core half-cycles per period (1.5x, 2.5x, 3.5x) are as easy to produce as the even ones.

A configuration write loads a pattern vector, a 4-bit start phase and an 8-bit feedback enable into a pending copy. The pending copy takes over only in a core cycle where the current clock is low in both halves, and that cycle is driven low. A high pulse is therefore never cut short. The loop length is the shortest repeat period of the pattern. A zero feedback enable parks the clock low. Alongside the active-low pin pair, the block gives one-cycle strobes for rising edges, falling edges and either edge. Downstream logic uses them to update outgoing data on both edges and to sample incoming data on the falling edge.

Top module: `fclk_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, fclkPairN is 2'b11 (clock low) and riseStb, fallStb and updStb are 0.
- R2: Each core cycle presents two consecutive pattern bits, taken LSB-first. The earlier half goes on fclkPairN[0] and the later half on fclkPairN[1], each inverted (pattern bit 1 = clock high = pin 0).
- R3: The loop length L is the smallest p in 2..16 with bit i equal to bit i+p for every valid i. For the standard encodings it is 3,4,5,6,7,8,10,12,14,16 for 9249, 3333, 8C63, 71C7, C387, 0F0F, 7C1F, F03F, C07F, 00FF.
- R4: A newly applied pattern starts at half-bit index (phase mod L).
- R5: A feedback enable of zero keeps the clock parked: fclkPairN stays 2'b11 and no strobe fires. Any nonzero value lets the pattern run.
- R6: A pending configuration is applied only in a cycle whose two current halves are both low. That cycle's pin pair is 2'b11, so no high pulse ever has a length other than one of the two patterns' own high runs.
- R7: From a parked clock, a write sampled at edge E is applied at edge E+1, and its first pattern pair appears on the pins after edge E+2.
- R8: riseStb is 1 for exactly the cycles whose pair holds a low-to-high step, counting the step from the previous cycle's later half into this cycle's earlier half.
- R9: fallStb is 1 for exactly the cycles whose pair holds a high-to-low step, with the same cross-cycle rule as R8.
- R10: updStb is 1 exactly when riseStb or fallStb is 1.
- R11: When several writes arrive before a pending configuration is applied, the most recent one is the one that takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgWrite | input | 1 | One-cycle configuration write |
| cfgClkVec | input | 16 | Clock pattern vector |
| cfgPhase | input | 4 | Start phase in half-cycles |
| cfgFdbk | input | 8 | Feedback enable, zero parks the clock |
| fclkPairN | output | 2 | Active-low clock levels, [0] earlier half, [1] later half |
| riseStb | output | 1 | Rising edge in this cycle |
| fallStb | output | 1 | Falling edge in this cycle |
| updStb | output | 1 | Any edge in this cycle (output update) |

## Verification
Every standard ratio encoding is run from a parked start and compared half by half, together with the strobes. This separates the odd-half ratios, whose pair alignment shifts from cycle to cycle, from the even ones, and it exposes wrong loop lengths or wrong bit order. A non-zero phase on a short loop separates correct modulo start offsets from plain offsets. A live change from 4.0x to 3.5x, and a back-to-back double write, are captured as raw half-bit streams whose high-run lengths show whether a truncated pulse appeared and which write won. A zero feedback enable, applied both from reset and while running, shows whether the clock parks low.

// File: rtl/fclk_pkg.sv
package fclk_pkg;
  parameter int VecW = 16;
  parameter int PhW  = 4;
  parameter int FbW  = 8;
  localparam int PosW = $clog2(VecW);
  localparam int LenW = PosW + 1;

  typedef struct packed {
    logic latchPend;
    logic swap;
  } fclkCtlT;

  // smallest repeat period (2..VecW) of the pattern
  function automatic logic [LenW-1:0] minPeriod(input logic [VecW-1:0] v);
    logic [LenW-1:0] best;
    logic ok;
    best = LenW'(VecW);
    for (int p = VecW - 1; p >= 2; p--) begin
      ok = 1'b1;
      for (int i = 0; i < VecW - p; i++) begin
        if (v[i] != v[i+p]) ok = 1'b0;
      end
      if (ok) best = LenW'(p);
    end
    return best;
  endfunction
endpackage

// File: rtl/fclk_ctrl.sv
module fclk_ctrl
  import fclk_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            cfgWrite,
  input  logic            curHalf0,
  input  logic            curHalf1,
  input  logic [LenW-1:0] actLen,
  input  logic [LenW-1:0] pendLen,
  input  logic [PhW-1:0]  pendPhase,
  output fclkCtlT         ctl,
  output logic [PosW-1:0] pos
);
  logic            pendValid;
  logic            swapNow;
  logic [LenW-1:0] posPlus2;
  logic [LenW-1:0] posNext;
  logic [LenW-1:0] startPos;

  assign swapNow  = pendValid && !curHalf0 && !curHalf1;
  assign posPlus2 = {1'b0, pos} + LenW'(2);
  assign posNext  = (posPlus2 >= actLen) ? posPlus2 - actLen : posPlus2;
  assign startPos = LenW'(pendPhase) % pendLen;

  always_comb begin
    ctl.latchPend = cfgWrite;
    ctl.swap      = swapNow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendValid <= 1'b0;
      pos       <= '0;
    end else begin
      if (cfgWrite)     pendValid <= 1'b1;
      else if (swapNow) pendValid <= 1'b0;
      if (swapNow) pos <= startPos[PosW-1:0];
      else         pos <= posNext[PosW-1:0];
    end
  end
endmodule

// File: rtl/fclk_dp.sv
module fclk_dp
  import fclk_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  fclkCtlT         ctl,
  input  logic [PosW-1:0] pos,
  input  logic [VecW-1:0] cfgClkVec,
  input  logic [PhW-1:0]  cfgPhase,
  input  logic [FbW-1:0]  cfgFdbk,
  output logic            curHalf0,
  output logic            curHalf1,
  output logic [LenW-1:0] actLen,
  output logic [LenW-1:0] pendLen,
  output logic [PhW-1:0]  pendPhase,
  output logic [1:0]      fclkPairN,
  output logic            riseStb,
  output logic            fallStb,
  output logic            updStb
);
  logic [VecW-1:0] pendVec, actVec;
  logic [FbW-1:0]  pendFb, actFb;
  logic            running;
  logic [LenW-1:0] idxRaw;
  logic [PosW-1:0] idx1;
  logic            lastHi;
  logic            riseNext, fallNext;

  assign actLen   = minPeriod(actVec);
  assign pendLen  = minPeriod(pendVec);
  assign running  = |actFb;
  assign idxRaw   = {1'b0, pos} + LenW'(1);
  assign idx1     = (idxRaw >= actLen) ? '0 : idxRaw[PosW-1:0];
  assign curHalf0 = running & actVec[pos];
  assign curHalf1 = running & actVec[idx1];
  assign riseNext = (!lastHi & curHalf0) | (!curHalf0 & curHalf1);
  assign fallNext = (lastHi & !curHalf0) | (curHalf0 & !curHalf1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pendVec   <= '0;
      pendPhase <= '0;
      pendFb    <= '0;
      actVec    <= '0;
      actFb     <= '0;
    end else begin
      if (ctl.latchPend) begin
        pendVec   <= cfgClkVec;
        pendPhase <= cfgPhase;
        pendFb    <= cfgFdbk;
      end
      if (ctl.swap) begin
        actVec <= pendVec;
        actFb  <= pendFb;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fclkPairN <= 2'b11;
      lastHi    <= 1'b0;
      riseStb   <= 1'b0;
      fallStb   <= 1'b0;
      updStb    <= 1'b0;
    end else begin
      fclkPairN <= ~{curHalf1, curHalf0};
      lastHi    <= curHalf1;
      riseStb   <= riseNext;
      fallStb   <= fallNext;
      updStb    <= riseNext | fallNext;
    end
  end
endmodule

// File: rtl/fclk_gen.sv
module fclk_gen
  import fclk_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            cfgWrite,
  input  logic [VecW-1:0] cfgClkVec,
  input  logic [PhW-1:0]  cfgPhase,
  input  logic [FbW-1:0]  cfgFdbk,
  output logic [1:0]      fclkPairN,
  output logic            riseStb,
  output logic            fallStb,
  output logic            updStb
);
  fclkCtlT         ctlBus;
  logic [PosW-1:0] pos;
  logic            curHalf0, curHalf1;
  logic [LenW-1:0] actLen, pendLen;
  logic [PhW-1:0]  pendPhase;
  logic            swapNow;

  assign swapNow = ctlBus.swap;

  fclk_ctrl uCtrl (
    .clk(clk), .rst(rst), .cfgWrite(cfgWrite),
    .curHalf0(curHalf0), .curHalf1(curHalf1),
    .actLen(actLen), .pendLen(pendLen), .pendPhase(pendPhase),
    .ctl(ctlBus), .pos(pos)
  );

  fclk_dp uDp (
    .clk(clk), .rst(rst), .ctl(ctlBus), .pos(pos),
    .cfgClkVec(cfgClkVec), .cfgPhase(cfgPhase), .cfgFdbk(cfgFdbk),
    .curHalf0(curHalf0), .curHalf1(curHalf1),
    .actLen(actLen), .pendLen(pendLen), .pendPhase(pendPhase),
    .fclkPairN(fclkPairN), .riseStb(riseStb), .fallStb(fallStb), .updStb(updStb)
  );
endmodule

// File: rtl/fclk_gen_chk.sv
module fclk_gen_chk
  import fclk_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [1:0]      fclkPairN,
  input logic            riseStb,
  input logic            fallStb,
  input logic            updStb,
  input logic            swapNow,
  input logic [PosW-1:0] pos,
  input logic [LenW-1:0] actLen
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (fclkPairN == 2'b11 && !riseStb && !fallStb && !updStb));

  p_pos_in_loop_r3: assert property (@(posedge clk) disable iff (rst)
    {1'b0, pos} < actLen);

  p_swap_low_r6: assert property (@(posedge clk) disable iff (rst)
    swapNow |=> (fclkPairN == 2'b11));

  p_rise_step_r8: assert property (@(posedge clk) disable iff (rst)
    riseStb |-> ((!fclkPairN[0] && $past(fclkPairN[1])) || (fclkPairN[0] && !fclkPairN[1])));

  p_fall_step_r9: assert property (@(posedge clk) disable iff (rst)
    fallStb |-> ((fclkPairN[0] && !$past(fclkPairN[1])) || (!fclkPairN[0] && fclkPairN[1])));

  p_upd_any_r10: assert property (@(posedge clk) disable iff (rst)
    updStb == (riseStb || fallStb));
endmodule

bind fclk_gen fclk_gen_chk uChk (
  .clk(clk), .rst(rst), .fclkPairN(fclkPairN), .riseStb(riseStb),
  .fallStb(fallStb), .updStb(updStb), .swapNow(swapNow), .pos(pos), .actLen(actLen)
);

// File: tb/fclk_gen_test.sv
module fclk_gen_test;
  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgWrite = 1'b0;
  logic [15:0] cfgClkVec = '0;
  logic [3:0]  cfgPhase = '0;
  logic [7:0]  cfgFdbk = '0;
  logic [1:0]  fclkPairN;
  logic        riseStb, fallStb, updStb;

  int nChecks = 0;
  int nFail = 0;
  logic sb [0:255];
  int nHalf;

  logic [15:0] tVec [10] = '{16'h9249, 16'h3333, 16'h8C63, 16'h71C7, 16'hC387,
                             16'h0F0F, 16'h7C1F, 16'hF03F, 16'hC07F, 16'h00FF};
  logic [3:0]  tPh  [10] = '{4'h5, 4'h0, 4'h5, 4'h0, 4'hA, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0};
  logic [7:0]  tFb  [10] = '{8'h02, 8'h01, 8'h02, 8'h10, 8'h04, 8'h01, 8'h40, 8'h10, 8'h04, 8'h01};
  int          tLen [10] = '{3, 4, 5, 6, 7, 8, 10, 12, 14, 16};

  always #(ClkPeriod/2) clk = ~clk;

  fclk_gen uut (
    .clk(clk), .rst(rst), .cfgWrite(cfgWrite), .cfgClkVec(cfgClkVec),
    .cfgPhase(cfgPhase), .cfgFdbk(cfgFdbk), .fclkPairN(fclkPairN),
    .riseStb(riseStb), .fallStb(fallStb), .updStb(updStb)
  );

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; cfgWrite = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "pins in reset", int'(fclkPairN), 3);
    check("R1", "strobes in reset", int'({riseStb, fallStb, updStb}), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "pins after reset", int'(fclkPairN), 3);
  endtask

  task automatic writeCfg(logic [15:0] v, logic [3:0] ph, logic [7:0] fb);
    cfgWrite = 1'b1; cfgClkVec = v; cfgPhase = ph; cfgFdbk = fb;
    @(posedge clk);
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  // compares the exact pin/strobe stream of a pattern started from parked
  task automatic runExact(string req, logic [15:0] v, int len, int off, int cycles);
    logic prevHi;
    logic e0, e1;
    int h0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    prevHi = 1'b0;
    for (int c = 0; c < cycles; c++) begin
      h0 = (off + 2*c) % len;
      e0 = v[h0];
      e1 = v[(h0 + 1) % len];
      check(c == 0 ? {req, " R7"} : req, "pin pair", int'(fclkPairN), int'(~{e1, e0} & 2'b11));
      check("R8", "riseStb", int'(riseStb), int'((!prevHi & e0) | (!e0 & e1)));
      check("R9", "fallStb", int'(fallStb), int'((prevHi & !e0) | (e0 & !e1)));
      check("R10", "updStb", int'(updStb), int'(((!prevHi & e0) | (!e0 & e1)) | ((prevHi & !e0) | (e0 & !e1))));
      prevHi = e1;
      @(negedge clk);
    end
  endtask

  task automatic testRatios();
    for (int k = 0; k < 10; k++) begin
      doReset();
      writeCfg(tVec[k], tPh[k], tFb[k]);
      runExact("R2 R3", tVec[k], tLen[k], int'(tPh[k]) % tLen[k], 2*tLen[k] + 2);
    end
  endtask

  task automatic testPhase();
    doReset();
    writeCfg(16'h3333, 4'd3, 8'h01);
    runExact("R4", 16'h3333, 4, 3, 10);
    doReset();
    writeCfg(16'h9249, 4'd14, 8'h02);
    runExact("R4", 16'h9249, 3, 2, 8);
  endtask

  task automatic testPark();
    doReset();
    writeCfg(16'h3333, 4'd0, 8'h00);
    for (int c = 0; c < 20; c++) begin
      check("R5", "parked pins", int'(fclkPairN), 3);
      check("R5", "parked strobes", int'({riseStb, fallStb, updStb}), 0);
      @(negedge clk);
    end
    writeCfg(16'h3333, 4'd0, 8'h01);
    repeat (6) @(negedge clk);
    writeCfg(16'h3333, 4'd0, 8'h00);
    repeat (6) @(negedge clk);
    for (int c = 0; c < 10; c++) begin
      check("R5", "re-parked pins", int'(fclkPairN), 3);
      check("R5", "re-parked strobes", int'(updStb), 0);
      @(negedge clk);
    end
  endtask

  task automatic capture(int cycles);
    nHalf = 0;
    for (int c = 0; c < cycles; c++) begin
      sb[nHalf]     = ~fclkPairN[0];
      sb[nHalf + 1] = ~fclkPairN[1];
      nHalf += 2;
      @(negedge clk);
    end
  endtask

  // checks each complete high run against two allowed lengths; returns last run
  task automatic checkRuns(string req, int okA, int okB, output int lastRun);
    int run;
    bit inRun;
    bit complete;
    run = 0; inRun = 0; complete = 0; lastRun = -1;
    for (int i = 0; i < nHalf; i++) begin
      if (sb[i]) begin
        if (!inRun) begin inRun = 1; run = 0; complete = (i != 0); end
        run++;
      end else if (inRun) begin
        inRun = 0;
        if (complete) begin
          check(req, "high run length", run, (run == okA) ? okA : okB);
          lastRun = run;
        end
      end
    end
  endtask

  task automatic testLiveChange();
    int lastRun;
    doReset();
    writeCfg(16'h0F0F, 4'd0, 8'h01);
    repeat (9) @(negedge clk);
    writeCfg(16'hC387, 4'hA, 8'h04);
    capture(60);
    checkRuns("R6", 4, 3, lastRun);
    check("R6", "new pattern run", lastRun, 3);
  endtask

  task automatic testLastWins();
    int lastRun;
    doReset();
    writeCfg(16'h0F0F, 4'd0, 8'h01);
    repeat (5) @(negedge clk);
    cfgWrite = 1'b1; cfgClkVec = 16'h71C7; cfgPhase = 4'd0; cfgFdbk = 8'h10;
    @(posedge clk); @(negedge clk);
    cfgClkVec = 16'h7C1F; cfgFdbk = 8'h40;
    @(posedge clk); @(negedge clk);
    cfgWrite = 1'b0;
    capture(60);
    checkRuns("R11", 4, 5, lastRun);
    check("R11", "final run from last write", lastRun, 5);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin : mainSeq
    testRatios();
    testPhase();
    testPark();
    testLiveChange();
    testLastWins();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule